// File: doc/BRIEF.md
# Framed Serial Codec Register Accessor

This block gives a host CPU read and write access to the sixteen control registers of an external codec. The codec sits on a continuous framed serial link. Software loads one 21-bit command word through a simple write port. The command holds a register address, a direction bit and sixteen bits of write data. At every rising edge of the external frame-sync input, the block takes the most recently written command into a 64-bit shifter and sends it MSB first on the transmit line during the first 64 bit periods of the frame (subframe 0).

The codec answers within the same 64 bit periods on the receive line. Its answer echoes the address and returns the current contents of the addressed register. The block answers reads and writes the same way. After the last reply bit arrives, the block rebuilds the command/result word from the echoed address and the returned data, with the direction bit cleared, and presents it on the CPU read port. A write therefore also acts as a read. In its own frame, a write returns the value the register held before the write.

The command is reissued in every frame until software writes a new one. This gives continuous polling or refreshing of one register. The block runs on the bit clock, and frame sync is sampled on that clock.

Top module: `codec_reg_access`

## Requirements
- R1: The command/result word is 21 bits: bits 20:17 are the codec register address, bit 16 is the direction (1 = write, 0 = read) and bits 15:0 are the data. A single CPU write loads all three fields together.
- R2: After reset the result word reads 0, the transmit line is 0 and the stored command is 0, so the first frame issues a read of address 0.
- R3: A command is taken into the frame only at a rising edge of frame sync. A CPU write made during a frame, or on the very edge that starts a frame, leaves that frame's transmitted bits unchanged and takes effect in the following frame.
- R4: Frame bits are numbered from 0 in transmit order, and bit k is driven in the k-th bit period after the frame-sync edge. Bits 35..38 carry the address, most significant bit first. Bit 39 carries the direction bit. Bits 40..55 carry the data, most significant bit first. Every other bit, and the line outside the 64 bit periods, is 0.
- R5: The receive line is sampled in the same bit periods. The result word takes its address from received bits 35..38 and its data from received bits 48..63 (MSB first), and its direction bit is cleared to 0. The result word is updated only once, at the edge that samples bit 63, and is readable from the next cycle. All other received bits have no effect on it.
- R6: Reads and writes both update the result word with the data the codec returns. In the frame that carries a write, this is the register's previous contents.
- R7: A CPU write does not change the result word. The read port shows the last completed access until the next frame completes.
- R8: The last written command is sent again in every frame until software writes a new one. A repeated write therefore returns the newly written value one frame later.
- R9: When a new frame-sync edge falls on the same edge that samples bit 63, the reply of the ending frame is stored and the next frame starts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; a rising edge starts a frame |
| cpu_we | input | 1 | CPU write strobe for the command word |
| cpu_wdata | input | 21 | Command word {address, direction, data} |
| cpu_rdata | output | 21 | Result of the last completed access |
| txd | output | 1 | Serial data to the codec |
| rxd | input | 1 | Serial data from the codec |

## Verification
Two functions can fall on the same clock edge: storing the reply of an ending frame and loading the command for the next frame. The bench provokes this by running frames back to back, with each new frame-sync edge landing exactly on the bit-63 sampling edge. It then checks that the result word read at the first bit of the new frame holds the old frame's reply, and that the new frame's bits match the command model. A second coincidence is a CPU write on the frame-start edge itself. This is judged by requiring that the frame starting on that edge still transmits the previous command, bit for bit.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 16;
  localparam int FRAME_BITS  = 64;
  localparam int CMD_W       = ADDR_W + 1 + DATA_W;
  localparam int CNT_W       = $clog2(FRAME_BITS);
  localparam int TX_ADDR_POS = 35;
  localparam int TX_RW_POS   = TX_ADDR_POS + ADDR_W;
  localparam int TX_DATA_POS = TX_RW_POS + 1;
  localparam int RX_ADDR_POS = 35;
  localparam int RX_DATA_POS = FRAME_BITS - DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  // frame bit k (transmit order) lives at vector index FRAME_BITS-1-k
  function automatic int vidx(input int k);
    return FRAME_BITS - 1 - k;
  endfunction

  function automatic logic [FRAME_BITS-1:0] pack_frame(input cmd_t c);
    logic [FRAME_BITS-1:0] v;
    v = '0;
    for (int i = 0; i < ADDR_W; i++) v[vidx(TX_ADDR_POS + i)] = c.addr[ADDR_W-1-i];
    v[vidx(TX_RW_POS)] = c.wr;
    for (int i = 0; i < DATA_W; i++) v[vidx(TX_DATA_POS + i)] = c.data[DATA_W-1-i];
    return v;
  endfunction

  function automatic cmd_t unpack_reply(input logic [FRAME_BITS-1:0] w);
    cmd_t r;
    r.wr = 1'b0;
    for (int i = 0; i < ADDR_W; i++) r.addr[ADDR_W-1-i] = w[vidx(RX_ADDR_POS + i)];
    for (int i = 0; i < DATA_W; i++) r.data[DATA_W-1-i] = w[vidx(RX_DATA_POS + i)];
    return r;
  endfunction

  function automatic logic tx_field_bit(input int k);
    return (k >= TX_ADDR_POS) && (k < TX_DATA_POS + DATA_W);
  endfunction
endpackage

// File: rtl/crx_frame_timer.sv
module crx_frame_timer #(
  parameter int FRAME_BITS = crx_pkg::FRAME_BITS,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             frame_start,
  output logic             active,
  output logic [CNT_W-1:0] bit_idx,
  output logic             reply_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic fsync_q;

  assign frame_start = fsync & ~fsync_q;
  assign reply_done  = active && (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync_q <= 1'b0;
      active  <= 1'b0;
      bit_idx <= '0;
    end else begin
      fsync_q <= fsync;
      if (frame_start) begin
        active  <= 1'b1;
        bit_idx <= '0;
      end else if (active) begin
        if (bit_idx == LAST) begin
          active  <= 1'b0;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crx_tx_serializer.sv
module crx_tx_serializer #(
  parameter int FRAME_BITS = crx_pkg::FRAME_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 active,
  input  crx_pkg::cmd_t        cmd,
  output logic                 txd
);
  logic [FRAME_BITS-1:0] shifter;

  always_ff @(posedge clk) begin
    if (!rst_n)           shifter <= '0;
    else if (frame_start) shifter <= crx_pkg::pack_frame(cmd);
    else if (active)      shifter <= {shifter[FRAME_BITS-2:0], 1'b0};
  end

  assign txd = active & shifter[FRAME_BITS-1];
endmodule

// File: rtl/crx_rx_deserializer.sv
module crx_rx_deserializer #(
  parameter int FRAME_BITS = crx_pkg::FRAME_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic                  rxd,
  output logic [FRAME_BITS-1:0] rx_word
);
  logic [FRAME_BITS-2:0] rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n)      rx_sh <= '0;
    else if (active) rx_sh <= rx_word[FRAME_BITS-2:0];
  end

  // word as it stands including the bit sampled on this edge
  assign rx_word = {rx_sh, rxd};
endmodule

// File: rtl/codec_reg_access.sv
module codec_reg_access #(
  parameter int FRAME_BITS = crx_pkg::FRAME_BITS,
  parameter int CMD_W      = crx_pkg::CMD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             cpu_we,
  input  logic [CMD_W-1:0] cpu_wdata,
  output logic [CMD_W-1:0] cpu_rdata,
  output logic             txd,
  input  logic             rxd
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic                  frame_start;
  logic                  active;
  logic [CNT_W-1:0]      bit_idx;
  logic                  reply_done;
  logic [FRAME_BITS-1:0] rx_word;
  crx_pkg::cmd_t         cmd_next;
  crx_pkg::cmd_t         cmd_live;
  crx_pkg::cmd_t         result;

  crx_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .frame_start(frame_start),
    .active(active), .bit_idx(bit_idx), .reply_done(reply_done)
  );

  crx_tx_serializer #(.FRAME_BITS(FRAME_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
    .cmd(cmd_next), .txd(txd)
  );

  crx_rx_deserializer #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(active), .rxd(rxd), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_next <= '0;
      cmd_live <= '0;
      result   <= '0;
    end else begin
      if (cpu_we)      cmd_next <= crx_pkg::cmd_t'(cpu_wdata);
      if (frame_start) cmd_live <= cmd_next;
      if (reply_done)  result   <= crx_pkg::unpack_reply(rx_word);
    end
  end

  assign cpu_rdata = result;
endmodule

// File: rtl/crx_checks.sv
module crx_checks (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      frame_start,
  input logic                      active,
  input logic [crx_pkg::CNT_W-1:0] bit_idx,
  input logic                      reply_done,
  input logic                      txd,
  input logic [crx_pkg::CMD_W-1:0] cpu_rdata,
  input crx_pkg::cmd_t             cmd_live
);
  // R3: a frame-sync rise opens a frame at bit 0
  a_r3_start_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (active && bit_idx == '0));

  // R3: the command of a running frame is frozen
  a_r3_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_start) |=> $stable(cmd_live));

  // R4: bits outside the fields are zero
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !crx_pkg::tx_field_bit(int'(bit_idx))) |-> !txd);

  // R4: line is quiet between frames
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !txd);

  // R4: direction bit appears in bit period 39
  a_r4_rw_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_idx == crx_pkg::CNT_W'(crx_pkg::TX_RW_POS)) |-> (txd == cmd_live.wr));

  // R5: result changes only when a reply completes
  a_r5_update_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !reply_done |=> $stable(cpu_rdata));

  // R5: returned word has direction cleared
  a_r5_rw_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    reply_done |=> !cpu_rdata[crx_pkg::DATA_W]);
endmodule

bind codec_reg_access crx_checks i_checks (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
  .bit_idx(bit_idx), .reply_done(reply_done), .txd(txd),
  .cpu_rdata(cpu_rdata), .cmd_live(cmd_live)
);

// File: tb/test_codec_reg_access.sv
module test_codec_reg_access;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        cpu_we = 1'b0;
  logic [20:0] cpu_wdata = '0;
  logic [20:0] cpu_rdata;
  logic        txd;
  logic        rxd = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] creg [16];
  logic [20:0] model_next = '0;
  logic [20:0] last_result = '0;
  logic [20:0] pend_exp = '0;
  bit          pend = 0;
  string       pend_tag = "";

  always #4 clk = ~clk;

  codec_reg_access i_codec_reg_access (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected transmit bit k for command c, written per field
  function automatic logic exp_tx(input logic [20:0] c, input int k);
    if (k >= 35 && k <= 38) return c[20 - (k - 35)];
    if (k == 39)            return c[16];
    if (k >= 40 && k <= 55) return c[15 - (k - 40)];
    return 1'b0;
  endfunction

  task automatic check_pending();
    if (pend) begin
      chk(cpu_rdata == pend_exp, pend_tag, 32'(cpu_rdata), 32'(pend_exp));
      last_result = pend_exp;
      pend = 0;
    end
  endtask

  // entered at a negedge; mid_k < 0 means no mid-frame write
  task automatic run_frame(input int gap, input bit wr_start, input logic [20:0] wval,
                           input int mid_k, input logic [20:0] mval, input string tag);
    logic [20:0] fcmd;
    logic [3:0]  addr;
    logic        rw;
    logic [15:0] wdat;
    logic [15:0] rd_val;
    int          bad;
    bad = 0; addr = '0; rw = 0; wdat = '0; rd_val = '0;
    fsync = 1'b1;
    fcmd = model_next;
    if (wr_start) begin
      cpu_we = 1'b1; cpu_wdata = wval; model_next = wval;
    end
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      cpu_we = 1'b0;
      if (k == 0) begin
        fsync = 1'b0;
        check_pending();
      end
      if (mid_k >= 0 && k == mid_k + 1)
        chk(cpu_rdata == last_result, "R7 write leaves result", 32'(cpu_rdata), 32'(last_result));
      if (k == mid_k) begin
        cpu_we = 1'b1; cpu_wdata = mval; model_next = mval;
      end
      if (txd !== exp_tx(fcmd, k)) bad++;
      if (k >= 35 && k <= 38) addr[38 - k] = txd;
      if (k == 39) begin rw = txd; rd_val = creg[addr]; end
      if (k >= 40 && k <= 55) wdat[55 - k] = txd;
      if (k >= 35 && k <= 38)      rxd = addr[38 - k];
      else if (k >= 48)            rxd = rd_val[63 - k];
      else                         rxd = k[0] ^ k[2];
    end
    chk(bad == 0, "R3 R4 frame bits", 32'(bad), 32'd0);
    if (rw) creg[addr] = wdat;
    pend_exp = {addr, 1'b0, rd_val};
    pend = 1;
    pend_tag = (gap == 0) ? {tag, " R9"} : tag;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      rxd = 1'b1;
      if (g == 0) check_pending();
      chk(txd == 1'b0, "R4 idle line", 32'(txd), 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) creg[i] = 16'h5A00 ^ 16'(i * 16'h1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_rdata == '0, "R2 reset result", 32'(cpu_rdata), 32'd0);
    chk(txd == 1'b0, "R2 reset line", 32'(txd), 32'd0);
    // R2: first frame reads address 0
    run_frame(4, 0, '0, -1, '0, "R2 R5 default read");
    // writes: mid-frame write, then write frame returns old (R6), repeat returns new (R8)
    for (int a = 0; a < 16; a++) begin
      logic [15:0] d;
      d = 16'(a * 16'h0F1D) ^ 16'hC3A5;
      run_frame(a % 3, 0, '0, 10 + a, {4'(a), 1'b1, d}, "R1 R5 prior");
      run_frame(a % 2, 0, '0, -1, '0, "R6 write returns old");
      run_frame(0, 0, '0, -1, '0, "R8 repeat returns new");
    end
    // reads: write lands on the frame-start edge, so that frame keeps the old command (R3)
    for (int a = 15; a >= 0; a--) begin
      run_frame(a % 2, 1, {4'(a), 1'b0, 16'hFFFF}, -1, '0, "R3 R5 edge write");
      run_frame(2, 0, '0, -1, '0, "R1 R5 read back");
    end
    @(negedge clk);
    check_pending();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule